// File: doc/BRIEF.md
# Single-Bit Manipulation ALU Slice

This slice performs the single-bit operations of an integer datapath on one 32-bit source word: force one bit to one, force it to zero, flip it, or read it out as a zero-extended value. The bit position is a five-bit index. It comes either from the low bits of the second register operand or from a short immediate field, and a select input chooses between the two. Every index wider than the operand width is taken modulo the width.

No separate mask decoder is used. The slice drives a shared logarithmic barrel shifter. For the three modifying operations, a small input multiplexer feeds the constant one into the shifter, which shifts it left to form a one-hot mask. For read-out and for the plain logical shifts that share the same hardware, the multiplexer feeds operand A instead. A bitwise-logic stage then merges the shifter output with operand A. The result is registered, so each operation takes exactly one clock cycle from the input handshake to the output. The output holds its last value while no new operation is offered.

Top module: `sbit_alu`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `valid_o` and `result_o` are cleared to zero at that edge.
- R2: An operation with `in_valid_i` high at a clock edge sets `valid_o` and presents its result on `result_o` right after that edge. `valid_o` is low after any edge where `in_valid_i` was low.
- R3: The bit index is `src_b_i[4:0]` when `idx_imm_sel_i` is 0 and `imm_i` when it is 1. Bits 31..5 of `src_b_i` never change the result.
- R4: Opcode 2 (set) returns `src_a_i | (1 << index)`.
- R5: Opcode 3 (clear) returns `src_a_i & ~(1 << index)`.
- R6: Opcode 4 (invert) returns `src_a_i ^ (1 << index)`.
- R7: Opcode 5 (extract) returns bit `index` of `src_a_i` in bit 0, and bits 31..1 are zero.
- R8: Opcode 0 returns `src_a_i` shifted left by the index, and opcode 1 returns it shifted right logically by the index. Vacated bits are zero in both cases.
- R9: Opcodes 6 and 7 return zero.
- R10: After an edge where `in_valid_i` is low, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | An operation is offered this cycle |
| op_i | input | 3 | Operation code (0 shl, 1 shr, 2 set, 3 clear, 4 invert, 5 extract) |
| idx_imm_sel_i | input | 1 | 0: index from src_b_i, 1: index from imm_i |
| src_a_i | input | 32 | Operand A, the word being manipulated |
| src_b_i | input | 32 | Register second operand, low five bits give the index |
| imm_i | input | 5 | Immediate bit index |
| valid_o | output | 1 | Result register holds a fresh result |
| result_o | output | 32 | Registered result |

## Verification
The only internal state is the result register and its valid flag. A wrong value there shows on `result_o` or `valid_o` one edge after the operation that caused it, and it then stays visible until the next accepted operation. Faults in the combinational path show in the same cycle as the registered result. A wrong shifter input selection or a bad shift stage appears as a mask at the wrong position, or as more than one set bit, at some index between 0 and 31. For this reason every modifying operation and every extract is swept over all 32 indices with operand values of all zeros, all ones and an alternating pattern. Because only the low bits of the register operand may count, a stage wired to the wrong amount bit would show at once when the upper bits are set.

// File: rtl/sbit_pkg.sv
package sbit_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_BSET = 3'd2,
    OP_BCLR = 3'd3,
    OP_BINV = 3'd4,
    OP_BEXT = 3'd5
  } sbit_op_e;

  function automatic logic op_uses_mask(input logic [2:0] op);
    return (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BINV);
  endfunction

  function automatic logic op_shifts_right(input logic [2:0] op);
    return (op == OP_SHR) || (op == OP_BEXT);
  endfunction

endpackage

// File: rtl/sbit_opsel.sv
module sbit_opsel
  import sbit_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [2:0]      op_i,
  input  logic            idx_imm_sel_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [IDXW-1:0] imm_i,
  output logic [XLEN-1:0] shift_data_o,
  output logic [IDXW-1:0] shift_amt_o,
  output logic            shift_right_o
);

  localparam logic [XLEN-1:0] ONE_WORD = XLEN'(1);

  logic [IDXW-1:0] reg_idx;

  // The register form uses the operand modulo the width.
  assign reg_idx = IDXW'(src_b_i % XLEN);

  always_comb begin
    shift_amt_o   = idx_imm_sel_i ? imm_i : reg_idx;
    shift_data_o  = op_uses_mask(op_i) ? ONE_WORD : src_a_i;
    shift_right_o = op_shifts_right(op_i);
  end

endmodule

// File: rtl/sbit_barrel.sv
module sbit_barrel #(
  parameter int XLEN = 32,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [IDXW-1:0] amt_i,
  input  logic            right_i,
  output logic [XLEN-1:0] data_o
);

  logic [XLEN-1:0] data_rev;
  logic [XLEN-1:0] core_in;
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] core_rev;
  logic [XLEN-1:0] stage [IDXW+1];

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign data_rev[i] = data_i[XLEN-1-i];
    assign core_rev[i] = core_out[XLEN-1-i];
  end

  assign core_in  = right_i ? data_i : data_rev;
  assign stage[0] = core_in;

  for (genvar k = 0; k < IDXW; k++) begin : g_stage
    assign stage[k+1] = amt_i[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign core_out = stage[IDXW];
  assign data_o   = right_i ? core_out : core_rev;

endmodule

// File: rtl/sbit_bitlogic.sv
module sbit_bitlogic
  import sbit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] shifted_i,
  output logic [XLEN-1:0] result_o
);

  always_comb begin
    unique case (op_i)
      OP_SHL,
      OP_SHR:  result_o = shifted_i;
      OP_BSET: result_o = src_a_i | shifted_i;
      OP_BCLR: result_o = src_a_i & ~shifted_i;
      OP_BINV: result_o = src_a_i ^ shifted_i;
      OP_BEXT: result_o = {{(XLEN-1){1'b0}}, shifted_i[0]};
      default: result_o = '0;
    endcase
  end

endmodule

// File: rtl/sbit_alu.sv
module sbit_alu
  import sbit_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            in_valid_i,
  input  logic [2:0]      op_i,
  input  logic            idx_imm_sel_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [IDXW-1:0] imm_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);

  logic [XLEN-1:0] shift_data;
  logic [IDXW-1:0] shift_amt;
  logic            shift_right;
  logic [XLEN-1:0] shift_out;
  logic [XLEN-1:0] comb_result;

  sbit_opsel #(.XLEN(XLEN), .IDXW(IDXW)) opsel_i (
    .op_i          (op_i),
    .idx_imm_sel_i (idx_imm_sel_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .imm_i         (imm_i),
    .shift_data_o  (shift_data),
    .shift_amt_o   (shift_amt),
    .shift_right_o (shift_right)
  );

  sbit_barrel #(.XLEN(XLEN), .IDXW(IDXW)) barrel_i (
    .data_i  (shift_data),
    .amt_i   (shift_amt),
    .right_i (shift_right),
    .data_o  (shift_out)
  );

  sbit_bitlogic #(.XLEN(XLEN)) logic_i (
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .shifted_i (shift_out),
    .result_o  (comb_result)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= comb_result;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> valid_o);

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> ($stable(result_o) && !valid_o));

  // R4
  set_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && op_i == OP_BSET) |=> result_o[$past(shift_amt)]);

  // R5
  clr_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && op_i == OP_BCLR) |=> !result_o[$past(shift_amt)]);

  // R7
  ext_upper_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && op_i == OP_BEXT) |=> (result_o[XLEN-1:1] == '0));

  // R6
  mask_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && op_uses_mask(op_i)) |-> $onehot(shift_out));

endmodule

// File: tb/sbit_alu_tb.sv
`timescale 1ns/1ps
module sbit_alu_tb_top;

  localparam int XLEN = 32;
  localparam int IDXW = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [2:0]      op;
  logic            sel_imm;
  logic [XLEN-1:0] a;
  logic [XLEN-1:0] b;
  logic [IDXW-1:0] imm;
  logic            valid_o;
  logic [XLEN-1:0] result_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sbit_alu #(.XLEN(XLEN), .IDXW(IDXW)) dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .in_valid_i    (in_valid),
    .op_i          (op),
    .idx_imm_sel_i (sel_imm),
    .src_a_i       (a),
    .src_b_i       (b),
    .imm_i         (imm),
    .valid_o       (valid_o),
    .result_o      (result_o)
  );

  function automatic logic [XLEN-1:0] model(input logic [2:0] o,
                                            input logic [XLEN-1:0] x,
                                            input int idx);
    logic [XLEN-1:0] m;
    m = XLEN'(1) << idx;
    case (o)
      3'd0: return x << idx;
      3'd1: return x >> idx;
      3'd2: return x | m;
      3'd3: return x & ~m;
      3'd4: return x ^ m;
      3'd5: return {31'b0, x[idx]};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic issue(input logic [2:0] o, input logic [XLEN-1:0] x,
                       input logic [XLEN-1:0] y, input logic [IDXW-1:0] im,
                       input logic s);
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; imm = im; sel_imm = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; op = '0; a = '0; b = '0; imm = '0; sel_imm = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, valid_o}, '0);
    check("R1 result", result_o, '0);
    rst = 1'b0;
  endtask

  task automatic t_single_bit_sweep();
    logic [XLEN-1:0] pats [3] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A};
    string tags [4] = '{"R4", "R5", "R6", "R7"};
    for (int p = 0; p < 3; p++) begin
      for (int o = 2; o <= 5; o++) begin
        for (int i = 0; i < XLEN; i++) begin
          issue(3'(o), pats[p], XLEN'(i), '0, 1'b0);
          check({tags[o-2], " sweep"}, result_o, model(3'(o), pats[p], i));
          check("R2 valid", {31'b0, valid_o}, 32'd1);
        end
      end
    end
  endtask

  task automatic t_plain_shifts();
    for (int i = 0; i < XLEN; i += 3) begin
      issue(3'd0, 32'h8000_0001, XLEN'(i), '0, 1'b0);
      check("R8 shl", result_o, model(3'd0, 32'h8000_0001, i));
      issue(3'd1, 32'hF000_000F, XLEN'(i), '0, 1'b0);
      check("R8 shr", result_o, model(3'd1, 32'hF000_000F, i));
    end
    issue(3'd1, 32'hFFFF_FFFF, 32'd31, '0, 1'b0);
    check("R8 shr31", result_o, 32'h0000_0001);
  endtask

  task automatic t_index_source();
    // Register form: upper bits of src_b must not matter.
    issue(3'd2, 32'h0, 32'hFFFF_FFE7, 5'd30, 1'b0);
    check("R3 reg idx", result_o, 32'h0000_0080);
    // Immediate form: src_b ignored entirely.
    issue(3'd2, 32'h0, 32'h0000_0003, 5'd30, 1'b1);
    check("R3 imm idx", result_o, 32'h4000_0000);
    issue(3'd5, 32'h8000_0000, 32'h0, 5'd31, 1'b1);
    check("R3 imm ext31", result_o, 32'h1);
    issue(3'd3, 32'hFFFF_FFFF, 32'h0000_0040, 5'd9, 1'b0);
    check("R3 reg idx wrap", result_o, 32'hFFFF_FFFE);
  endtask

  task automatic t_reserved();
    issue(3'd6, 32'hFFFF_FFFF, 32'd4, '0, 1'b0);
    check("R9 op6", result_o, '0);
    issue(3'd7, 32'h1234_5678, 32'd0, '0, 1'b0);
    check("R9 op7", result_o, '0);
  endtask

  task automatic t_hold();
    issue(3'd4, 32'h0000_FFFF, 32'd16, '0, 1'b0);
    check("R6 inv16", result_o, 32'h0001_FFFF);
    @(negedge clk);
    op = 3'd2; a = 32'hDEAD_BEEF; b = 32'd3; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 hold", result_o, 32'h0001_FFFF);
    check("R2 valid low", {31'b0, valid_o}, '0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_bit_sweep();
    t_plain_shifts();
    t_index_source();
    t_reserved();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule